// File: doc/BRIEF.md
# Recursive Eight-Neighbour Motion Vector Refinement Controller

This block steers the integer-pixel refinement of one block's motion vector. A search is launched with a starting vector and its matching cost (the winner of an earlier prediction stage), a symmetric clamp on vector magnitude and a limit on the number of refinement rounds. In each round the controller walks the eight one-pixel displacements around the current centre. It requests a sum-of-absolute-differences cost for each displacement it does not already know, through a simple request/response cost port. It then moves the centre to the cheapest position.

The walk ends when the centre beats or ties every neighbour, or when the round limit is met. A one-cycle completion pulse then presents the final vector, its cost and the number of rounds used. Costs computed in the round just finished are kept in a 3x3 window that shifts with the centre, so positions that stay inside the window are never requested twice in a row. Neighbours outside the clamp are skipped without a request and can never win.

Top module: `nbr_search_ctrl`

## Requirements
- R1: A `start` pulse while idle loads the start vector and cost as the centre and latches the clamp and round limit. With a round limit of 0, `done` pulses one cycle after `start` with the start vector, the start cost and a round count of 0, and no request is issued.
- R2: Neighbour cells use index k = 3*(dy+1) + (dx+1) for dx, dy in {-1,0,1}, where negative dy is the row above. Cell 4 is the centre. Within a round, requests are issued in ascending k, so the first is the upper-left cell and the scan proceeds in raster order.
- R3: A neighbour whose x or y magnitude exceeds `range_lim` is not requested and can never be selected.
- R4: After a move, every cell of the new 3x3 window that lay in the previous window reuses its known cost and is not requested again. The centre is never requested.
- R5: A neighbour replaces the centre only when its cost is strictly lower. Among equal-cost neighbours, the lowest k wins. The new centre moves by one pixel per axis at most.
- R6: Each evaluation of the window counts as one round. When the centre is the cheapest position after a round, the search ends with that centre.
- R7: When the round count reaches the nonzero round limit after a move, the search ends with the vector just moved to, and `final_iters` equals the limit.
- R8: `done` is high for exactly one cycle. While it is high, `final_mvx`, `final_mvy`, `final_sad` and `final_iters` give the result, and `busy` is high from the cycle after `start` until `done` falls.
- R9: A `start` pulse while busy is ignored and does not change the running search or its result.
- R10: `req_valid` is a one-cycle pulse with at most one request outstanding. The next request is not issued before `cost_valid` has returned the previous cost, which may arrive one or more cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a search (sampled while idle) |
| start_mvx | input | MV_W | Signed start vector x |
| start_mvy | input | MV_W | Signed start vector y |
| start_sad | input | SAD_W | Cost of the start vector |
| range_lim | input | MV_W-1 | Largest allowed vector magnitude per axis |
| max_iter | input | ITER_W | Round limit (0 = no refinement) |
| req_valid | output | 1 | Cost request pulse |
| req_mvx | output | MV_W | Signed x of requested vector |
| req_mvy | output | MV_W | Signed y of requested vector |
| cost_valid | input | 1 | Returned cost is valid |
| cost_sad | input | SAD_W | Returned cost |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| final_mvx | output | MV_W | Final vector x |
| final_mvy | output | MV_W | Final vector y |
| final_sad | output | SAD_W | Cost of the final vector |
| final_iters | output | ITER_W | Rounds performed |

## Verification
A cost surface where every position costs the same catches a design that moves on a tie instead of stopping after one round with eight requests. A surface where all neighbours are equal and cheaper than the centre catches a wrong tie order, which would show up as a move to any cell other than the upper-left one. A small clamp near the window edge exposes out-of-range requests. Comparing the full request sequence after diagonal and straight moves catches a broken window shift, which shows up as reissued, missing or reordered requests or as a wrong final cost. Short round limits, a zero limit and a stray `start` during a search check the stop rules and that the latched settings hold.

// File: rtl/nbr_search_pkg.sv
package nbr_search_pkg;

  localparam int NCELL  = 9;
  localparam int CENTRE = 4;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SCAN   = 3'd1,
    S_WAIT   = 3'd2,
    S_DECIDE = 3'd3,
    S_FIN    = 3'd4
  } srch_state_t;

  // column offset of window cell k (raster index)
  function automatic logic signed [1:0] off_x(input logic [3:0] k);
    case (k)
      4'd0, 4'd3, 4'd6: off_x = -2'sd1;
      4'd1, 4'd4, 4'd7: off_x = 2'sd0;
      default:          off_x = 2'sd1;
    endcase
  endfunction

  // row offset of window cell k (negative = upper row)
  function automatic logic signed [1:0] off_y(input logic [3:0] k);
    if (k < 4'd3)      off_y = -2'sd1;
    else if (k < 4'd6) off_y = 2'sd0;
    else               off_y = 2'sd1;
  endfunction

  // where a cell of the recentred window comes from: {hit, old index}
  function automatic logic [4:0] shift_src(input int k,
                                           input logic signed [1:0] mx,
                                           input logic signed [1:0] my);
    int sx;
    int sy;
    sx = (k % 3) - 1 + int'(mx);
    sy = (k / 3) - 1 + int'(my);
    if (sx >= -1 && sx <= 1 && sy >= -1 && sy <= 1)
      shift_src = {1'b1, 4'(3 * sy + sx + 4)};
    else
      shift_src = 5'd0;
  endfunction

endpackage

// File: rtl/nbr_cost_window.sv
module nbr_cost_window
  import nbr_search_pkg::*;
#(
  parameter int SAD_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [SAD_W-1:0]              load_cost,
  input  logic                          wr_en,
  input  logic [3:0]                    wr_idx,
  input  logic [SAD_W-1:0]              wr_cost,
  input  logic                          wr_elig,
  input  logic                          shift_en,
  input  logic signed [1:0]             shift_dx,
  input  logic signed [1:0]             shift_dy,
  output logic [NCELL-1:0][SAD_W-1:0]   cell_cost,
  output logic [NCELL-1:0]              cell_known,
  output logic [NCELL-1:0]              cell_elig
);

  logic [4:0] src [NCELL];

  for (genvar k = 0; k < NCELL; k++) begin : g_src
    assign src[k] = shift_src(k, shift_dx, shift_dy);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_cost  <= '0;
      cell_known <= '0;
      cell_elig  <= '0;
    end else if (load) begin
      for (int k = 0; k < NCELL; k++) begin
        cell_known[k] <= (k == CENTRE);
        cell_elig[k]  <= (k == CENTRE);
        cell_cost[k]  <= (k == CENTRE) ? load_cost : '0;
      end
    end else if (shift_en) begin
      for (int k = 0; k < NCELL; k++) begin
        if (src[k][4]) begin
          cell_cost[k]  <= cell_cost[src[k][3:0]];
          cell_known[k] <= cell_known[src[k][3:0]];
          cell_elig[k]  <= cell_elig[src[k][3:0]];
        end else begin
          cell_known[k] <= 1'b0;
          cell_elig[k]  <= 1'b0;
        end
      end
    end else if (wr_en) begin
      cell_cost[wr_idx]  <= wr_cost;
      cell_known[wr_idx] <= 1'b1;
      cell_elig[wr_idx]  <= wr_elig;
    end
  end

endmodule

// File: rtl/nbr_best_select.sv
module nbr_best_select
  import nbr_search_pkg::*;
#(
  parameter int SAD_W = 16
) (
  input  logic [NCELL-1:0][SAD_W-1:0] cell_cost,
  input  logic [NCELL-1:0]            cell_elig,
  output logic [3:0]                  best_idx,
  output logic [SAD_W-1:0]            best_cost
);

  // centre is the incumbent; strict less keeps the earliest raster cell on ties
  always_comb begin
    best_idx  = 4'(CENTRE);
    best_cost = cell_cost[CENTRE];
    for (int k = 0; k < NCELL; k++) begin
      if (k != CENTRE && cell_elig[k] && cell_cost[k] < best_cost) begin
        best_idx  = 4'(k);
        best_cost = cell_cost[k];
      end
    end
  end

endmodule

// File: rtl/nbr_cand_gen.sv
module nbr_cand_gen
  import nbr_search_pkg::*;
#(
  parameter int MV_W = 8
) (
  input  logic signed [MV_W-1:0] cx,
  input  logic signed [MV_W-1:0] cy,
  input  logic [3:0]             idx,
  input  logic [MV_W-2:0]        rng,
  output logic signed [MV_W-1:0] cand_x,
  output logic signed [MV_W-1:0] cand_y,
  output logic                   cand_ok
);

  localparam int EXT_W = MV_W + 1;

  logic signed [EXT_W-1:0] ex, ey;
  logic signed [EXT_W-1:0] mag_x, mag_y;
  logic [EXT_W-1:0]        lim;

  assign ex     = EXT_W'(cx) + EXT_W'(off_x(idx));
  assign ey     = EXT_W'(cy) + EXT_W'(off_y(idx));
  assign mag_x  = (ex < 0) ? -ex : ex;
  assign mag_y  = (ey < 0) ? -ey : ey;
  assign lim    = EXT_W'(rng);
  assign cand_ok = ($unsigned(mag_x) <= lim) && ($unsigned(mag_y) <= lim);
  assign cand_x = ex[MV_W-1:0];
  assign cand_y = ey[MV_W-1:0];

endmodule

// File: rtl/nbr_search_ctrl.sv
module nbr_search_ctrl
  import nbr_search_pkg::*;
#(
  parameter int MV_W   = 8,
  parameter int SAD_W  = 16,
  parameter int ITER_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic signed [MV_W-1:0] start_mvx,
  input  logic signed [MV_W-1:0] start_mvy,
  input  logic [SAD_W-1:0]       start_sad,
  input  logic [MV_W-2:0]        range_lim,
  input  logic [ITER_W-1:0]      max_iter,
  output logic                   req_valid,
  output logic signed [MV_W-1:0] req_mvx,
  output logic signed [MV_W-1:0] req_mvy,
  input  logic                   cost_valid,
  input  logic [SAD_W-1:0]       cost_sad,
  output logic                   busy,
  output logic                   done,
  output logic signed [MV_W-1:0] final_mvx,
  output logic signed [MV_W-1:0] final_mvy,
  output logic [SAD_W-1:0]       final_sad,
  output logic [ITER_W-1:0]      final_iters
);

  localparam int RNG_W = MV_W - 1;

  srch_state_t             state;
  logic [3:0]              ptr;
  logic signed [MV_W-1:0]  cx, cy;
  logic [RNG_W-1:0]        rng_q;
  logic [ITER_W-1:0]       maxit_q, iter;

  logic [NCELL-1:0][SAD_W-1:0] w_cost;
  logic [NCELL-1:0]            w_known, w_elig;
  logic signed [MV_W-1:0]      cand_x, cand_y;
  logic                        cand_ok;
  logic [3:0]                  best_idx;
  logic [SAD_W-1:0]            best_cost;

  // named internal events (also used by the checker)
  logic in_scan, ptr_live, scan_end, scan_skip, scan_oob, req_fire, got_cost;
  logic ev_decide, ev_centre_best, ev_move, load_ev;
  logic [ITER_W-1:0] iter_inc;

  assign in_scan        = (state == S_SCAN);
  assign ptr_live       = (ptr < 4'(NCELL));
  assign scan_end       = in_scan && !ptr_live;
  assign scan_skip      = in_scan && ptr_live && (ptr == 4'(CENTRE) || w_known[ptr]);
  assign scan_oob       = in_scan && ptr_live && !scan_skip && !cand_ok;
  assign req_fire       = in_scan && ptr_live && !scan_skip && cand_ok;
  assign got_cost       = (state == S_WAIT) && cost_valid;
  assign ev_decide      = (state == S_DECIDE);
  assign ev_centre_best = (best_idx == 4'(CENTRE));
  assign ev_move        = ev_decide && !ev_centre_best;
  assign load_ev        = (state == S_IDLE) && start;
  assign iter_inc       = iter + 1'b1;

  nbr_cost_window #(.SAD_W(SAD_W)) win_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_ev),
    .load_cost  (start_sad),
    .wr_en      (scan_oob || got_cost),
    .wr_idx     (ptr),
    .wr_cost    (cost_sad),
    .wr_elig    (got_cost),
    .shift_en   (ev_move),
    .shift_dx   (off_x(best_idx)),
    .shift_dy   (off_y(best_idx)),
    .cell_cost  (w_cost),
    .cell_known (w_known),
    .cell_elig  (w_elig)
  );

  nbr_best_select #(.SAD_W(SAD_W)) sel_i (
    .cell_cost (w_cost),
    .cell_elig (w_elig),
    .best_idx  (best_idx),
    .best_cost (best_cost)
  );

  nbr_cand_gen #(.MV_W(MV_W)) cand_i (
    .cx      (cx),
    .cy      (cy),
    .idx     (ptr),
    .rng     (rng_q),
    .cand_x  (cand_x),
    .cand_y  (cand_y),
    .cand_ok (cand_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ptr     <= '0;
      cx      <= '0;
      cy      <= '0;
      rng_q   <= '0;
      maxit_q <= '0;
      iter    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          cx      <= start_mvx;
          cy      <= start_mvy;
          rng_q   <= range_lim;
          maxit_q <= max_iter;
          iter    <= '0;
          ptr     <= '0;
          state   <= (max_iter == '0) ? S_FIN : S_SCAN;
        end
        S_SCAN: begin
          if (scan_end)                  state <= S_DECIDE;
          else if (scan_skip || scan_oob) ptr  <= ptr + 4'd1;
          else                           state <= S_WAIT;
        end
        S_WAIT: if (cost_valid) begin
          ptr   <= ptr + 4'd1;
          state <= S_SCAN;
        end
        S_DECIDE: begin
          iter <= iter_inc;
          ptr  <= '0;
          if (ev_centre_best) begin
            state <= S_FIN;
          end else begin
            cx    <= cx + MV_W'(off_x(best_idx));
            cy    <= cy + MV_W'(off_y(best_idx));
            state <= (iter_inc == maxit_q) ? S_FIN : S_SCAN;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_valid   = req_fire;
  assign req_mvx     = cand_x;
  assign req_mvy     = cand_y;
  assign busy        = (state != S_IDLE);
  assign done        = (state == S_FIN);
  assign final_mvx   = cx;
  assign final_mvy   = cy;
  assign final_sad   = w_cost[CENTRE];
  assign final_iters = iter;

endmodule

// File: rtl/nbr_search_chk.sv
module nbr_search_chk #(
  parameter int MV_W   = 8,
  parameter int ITER_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic                   req_valid,
  input logic signed [MV_W-1:0] req_mvx,
  input logic signed [MV_W-1:0] req_mvy,
  input logic signed [MV_W-1:0] cx,
  input logic signed [MV_W-1:0] cy,
  input logic [MV_W-2:0]        rng_q,
  input logic [ITER_W-1:0]      maxit_q,
  input logic [ITER_W-1:0]      final_iters,
  input logic                   ev_decide,
  input logic                   ev_centre_best,
  input logic                   ev_move
);

  localparam int EXT_W = MV_W + 1;

  logic signed [EXT_W-1:0] ax, ay, prev_x, prev_y, step_x, step_y;

  assign ax = (req_mvx < 0) ? -EXT_W'(req_mvx) : EXT_W'(req_mvx);
  assign ay = (req_mvy < 0) ? -EXT_W'(req_mvy) : EXT_W'(req_mvy);

  always_ff @(posedge clk) begin
    prev_x <= EXT_W'(cx);
    prev_y <= EXT_W'(cy);
  end

  assign step_x = EXT_W'(cx) - prev_x;
  assign step_y = EXT_W'(cy) - prev_y;

  p_req_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($unsigned(ax) <= EXT_W'(rng_q)) && ($unsigned(ay) <= EXT_W'(rng_q)));

  p_no_centre_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(req_mvx == cx && req_mvy == cy));

  p_move_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_move |=> (step_x >= -1 && step_x <= 1 && step_y >= -1 && step_y <= 1
                 && (step_x != 0 || step_y != 0)));

  p_stop_centre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_decide && ev_centre_best) |=> done);

  p_iter_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (final_iters <= maxit_q));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(rng_q) && $stable(maxit_q)));

  p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

endmodule

bind nbr_search_ctrl nbr_search_chk #(.MV_W(MV_W), .ITER_W(ITER_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .busy           (busy),
  .done           (done),
  .req_valid      (req_valid),
  .req_mvx        (req_mvx),
  .req_mvy        (req_mvy),
  .cx             (cx),
  .cy             (cy),
  .rng_q          (rng_q),
  .maxit_q        (maxit_q),
  .final_iters    (final_iters),
  .ev_decide      (ev_decide),
  .ev_centre_best (ev_centre_best),
  .ev_move        (ev_move)
);

// File: tb/nbr_search_ctrl_tb_top.sv
module nbr_search_ctrl_tb_top;

  localparam int MV_W   = 8;
  localparam int SAD_W  = 16;
  localparam int ITER_W = 6;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start = 1'b0;
  logic signed [MV_W-1:0] start_mvx = '0, start_mvy = '0;
  logic [SAD_W-1:0]       start_sad = '0;
  logic [MV_W-2:0]        range_lim = '0;
  logic [ITER_W-1:0]      max_iter = '0;
  logic                   req_valid;
  logic signed [MV_W-1:0] req_mvx, req_mvy;
  logic                   cost_valid = 1'b0;
  logic [SAD_W-1:0]       cost_sad = '0;
  logic                   busy, done;
  logic signed [MV_W-1:0] final_mvx, final_mvy;
  logic [SAD_W-1:0]       final_sad;
  logic [ITER_W-1:0]      final_iters;

  always #4 clk = ~clk;

  nbr_search_ctrl #(.MV_W(MV_W), .SAD_W(SAD_W), .ITER_W(ITER_W)) dut_i (.*);

  int nchk = 0, nfail = 0;

  // cost surface: 0 bowl around target, 1 flat, 2 tie pattern around anchor
  int cmode, tx, ty, anx, any;

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int model_cost(int x, int y);
    if (cmode == 1) return 77;
    if (cmode == 2) begin
      if (x == anx && y == any) return 100;
      if (iabs(x - anx) <= 1 && iabs(y - any) <= 1) return 50;
      return 200;
    end
    return (iabs(x - tx) + iabs(y - ty)) * 16 + (((x * 5) + (y * 3)) & 7);
  endfunction

  // expected results
  int exp_x, exp_y, exp_sad, exp_it, exp_n;
  int exp_rx [512];
  int exp_ry [512];

  task automatic ref_walk(int sx, int sy, int ssad, int rng, int mi);
    int c  [3][3];
    bit kn [3][3];
    bit el [3][3];
    int nc [3][3];
    bit nk [3][3];
    bit ne [3][3];
    int px, py, bi, bj, bc, it;
    px = sx; py = sy; it = 0; exp_n = 0;
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 3; i++) begin
        kn[j][i] = 0; el[j][i] = 0; c[j][i] = 0;
      end
    kn[1][1] = 1; el[1][1] = 1; c[1][1] = ssad;
    while (mi != 0) begin
      for (int j = 0; j < 3; j++)
        for (int i = 0; i < 3; i++) begin
          if ((i == 1 && j == 1) || kn[j][i]) continue;
          kn[j][i] = 1;
          if (iabs(px + i - 1) > rng || iabs(py + j - 1) > rng) begin
            el[j][i] = 0;
          end else begin
            el[j][i] = 1;
            c[j][i] = model_cost(px + i - 1, py + j - 1);
            exp_rx[exp_n] = px + i - 1;
            exp_ry[exp_n] = py + j - 1;
            exp_n++;
          end
        end
      bi = 1; bj = 1; bc = c[1][1];
      for (int j = 0; j < 3; j++)
        for (int i = 0; i < 3; i++)
          if (el[j][i] && !(i == 1 && j == 1) && c[j][i] < bc) begin
            bi = i; bj = j; bc = c[j][i];
          end
      it++;
      if (bi == 1 && bj == 1) break;
      for (int j = 0; j < 3; j++)
        for (int i = 0; i < 3; i++) begin
          int oi, oj;
          oi = i + bi - 1; oj = j + bj - 1;
          if (oi >= 0 && oi <= 2 && oj >= 0 && oj <= 2) begin
            nc[j][i] = c[oj][oi]; nk[j][i] = kn[oj][oi]; ne[j][i] = el[oj][oi];
          end else begin
            nc[j][i] = 0; nk[j][i] = 0; ne[j][i] = 0;
          end
        end
      c = nc; kn = nk; el = ne;
      px += bi - 1; py += bj - 1;
      if (it == mi) break;
    end
    exp_x = px; exp_y = py; exp_sad = c[1][1]; exp_it = it;
  endtask

  task automatic check(string tag, int act, int expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic run(string name, int sx, int sy, int rng, int mi, int maxlat, bit inject);
    int nreq, cyc, lat, cst;
    bit fin;
    ref_walk(sx, sy, model_cost(sx, sy), rng, mi);
    @(negedge clk);
    start = 1; start_mvx = MV_W'(sx); start_mvy = MV_W'(sy);
    start_sad = SAD_W'(model_cost(sx, sy));
    range_lim = (MV_W-1)'(rng); max_iter = ITER_W'(mi);
    @(negedge clk);
    start = 0;
    nreq = 0; cyc = 0; fin = 0;
    while (!fin) begin
      if (cyc > 4000) begin
        nfail++; nchk++;
        $display("FAIL %s watchdog: no done actual=0 expected=1", name);
        return;
      end
      if (done) begin
        fin = 1;
        check({name, " R6 final x"}, int'(final_mvx), exp_x);
        check({name, " R6 final y"}, int'(final_mvy), exp_y);
        check({name, " R5 final sad"}, int'(final_sad), exp_sad);
        check({name, " R7 rounds"}, int'(final_iters), exp_it);
        check({name, " R4 request count"}, nreq, exp_n);
        check({name, " R8 busy with done"}, int'(busy), 1);
        @(negedge clk); cyc++;
        check({name, " R8 done one cycle"}, int'(done), 0);
      end else if (req_valid) begin
        if (nreq < exp_n) begin
          check({name, " R2 request x"}, int'(req_mvx), exp_rx[nreq]);
          check({name, " R2 request y"}, int'(req_mvy), exp_ry[nreq]);
        end
        if (iabs(int'(req_mvx)) > rng || iabs(int'(req_mvy)) > rng)
          check({name, " R3 request outside clamp"}, 1, 0);
        cst = model_cost(int'(req_mvx), int'(req_mvy));
        nreq++;
        if (inject && nreq == 2) begin
          start = 1; start_mvx = 8'sd9; start_mvy = -8'sd9;
          start_sad = 16'd1; range_lim = '0; max_iter = 6'd1;
        end
        lat = (maxlat > 1) ? $urandom_range(1, maxlat) : 1;
        for (int w = 1; w < lat; w++) begin
          @(negedge clk); cyc++;
          start = 0;
          if (req_valid) check({name, " R10 second request while waiting"}, 1, 0);
        end
        @(negedge clk); cyc++;
        start = 0;
        if (req_valid && lat == 1) check({name, " R10 request held"}, 1, 0);
        cost_valid = 1; cost_sad = SAD_W'(cst);
        @(negedge clk); cyc++;
        cost_valid = 0;
      end else begin
        @(negedge clk); cyc++;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 reset busy", int'(busy), 0);
    check("R8 reset done", int'(done), 0);
    check("R10 reset req_valid", int'(req_valid), 0);

    // R1: zero round limit returns the start vector without requests
    cmode = 0; tx = 20; ty = -5;
    run("R1 zero limit", 3, 4, 30, 0, 1, 0);
    // R6 / R5: flat surface, centre wins every tie
    cmode = 1;
    run("R6 flat", -7, 2, 30, 10, 2, 0);
    // R5 / R2: equal neighbours cheaper than centre, upper-left wins
    cmode = 2; anx = 5; any = 5;
    run("R5 tie raster", 5, 5, 30, 10, 1, 0);
    // R7: limit cuts a long walk
    cmode = 0; tx = 40; ty = 40;
    run("R7 limit", 0, 0, 100, 3, 1, 0);
    // R3: clamp near the window edge
    tx = 30; ty = 0;
    run("R3 clamp", 2, 0, 2, 20, 2, 0);
    tx = -30; ty = -30;
    run("R3 corner clamp", -3, -3, 3, 20, 1, 0);
    // R4: straight and diagonal walks reuse the window
    tx = 12; ty = 0;
    run("R4 straight", 0, 0, 60, 40, 1, 0);
    tx = -10; ty = 10;
    run("R4 diagonal", 0, 0, 60, 40, 3, 0);
    // R9: stray start during a search
    tx = 6; ty = -8;
    run("R9 busy start", 1, 1, 50, 20, 2, 1);

    // random mix
    for (int n = 0; n < 40; n++) begin
      int rng, sx, sy;
      cmode = 0;
      rng = $urandom_range(2, 40);
      tx = $urandom_range(0, 80) - 40;
      ty = $urandom_range(0, 80) - 40;
      sx = $urandom_range(0, 2 * rng) - rng;
      sy = $urandom_range(0, 2 * rng) - rng;
      run("R5 random", sx, sy, rng, $urandom_range(0, 12), 3, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule